// File: doc/BRIEF.md
# Operand Shifter with Immediate Expansion

This block prepares the second operand of a 32-bit integer datapath. In shift mode it applies one of five shift operations (logical left, logical right, arithmetic right, rotate right, and a one-place rotate right that pulls the incoming carry flag into the top bit) to a 32-bit word, using an 8-bit shift amount. In immediate mode it turns a 12-bit encoded constant into a 32-bit word. The constant is either an 8-bit value with its top bit set, rotated into any position, or one of four byte-replication patterns.

Both modes also compute a carry-out. The block does not hold the status flags. It raises a carry-update indication, and the flag logic downstream decides whether to commit the new carry. The shift and expansion logic is purely combinational. One output register, with a valid/ready handshake on each side, carries the result into the next stage.

The input takes a new operation whenever `in_ready` is high. `in_ready` is high when the output register is empty, or when the output register is being drained in the same cycle. An accepted operation appears at the output on the next clock. It stays there, unchanged, until `out_ready` takes it. No input is lost and none is duplicated under back-pressure.

Top module: `bsx_operand_unit`

## Requirements
- R1: Shift code 0 (logical left) by 1 to 31 gives the operand shifted up, with zeros in the vacated low bits. The carry is the last bit shifted out of bit 31. An amount of 32 gives zero with carry equal to operand bit 0. An amount above 32 gives zero with carry 0.
- R2: Shift code 1 (logical right) by 1 to 31 gives the operand shifted down, with zeros in the vacated high bits. The carry is operand bit (amount-1). An amount of 32 gives zero with carry equal to operand bit 31. An amount above 32 gives zero with carry 0.
- R3: Shift code 2 (arithmetic right) fills the vacated bits with operand bit 31. For amounts of 32 or more, every result bit and the carry equal operand bit 31.
- R4: Shift code 3 (rotate right) rotates by the amount modulo 32. For any nonzero amount, the carry equals result bit 31.
- R5: Shift code 4 moves every bit down one place and loads the incoming carry into bit 31. The carry-out is operand bit 0. The amount is ignored.
- R6: With shift codes 0 to 3 and an amount of zero, the result equals the operand and the carry-out equals the incoming carry.
- R7: In immediate mode with field bits [11:10] not both zero, the result is {1, imm[6:0]} zero-extended and rotated right by imm[11:7]. The carry-out is result bit 31.
- R8: In immediate mode with imm[11:10] = 00, the byte imm[7:0] is placed according to imm[9:8]: 00 puts it in bits 7:0; 01 in bits 23:16 and 7:0; 10 in bits 31:24 and 15:8; 11 in all four bytes. All other bits are zero, and the carry-out equals the incoming carry.
- R9: `out_carry_upd` is high only if `in_flag_req` was high for that operation. It is then high for shift codes 0 to 3 with a nonzero amount, for shift code 4, and for the rotated immediate form. It is low otherwise.
- R10: An operation accepted on a clock edge (in_valid and in_ready both high) is presented with `out_valid` high after that same edge.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_carry` and `out_carry_upd` hold their values.
- R12: During and right after reset, `out_valid` is low and `in_ready` is high.
- R13: Shift codes 5 to 7 pass the operand and the incoming carry through unchanged, with `out_carry_upd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_imm_mode | input | 1 | 1 = expand immediate, 0 = shift operand |
| in_kind | input | 3 | Shift code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry) |
| in_amount | input | 8 | Shift amount |
| in_operand | input | 32 | Word to shift |
| in_imm12 | input | 12 | Encoded immediate |
| in_carry | input | 1 | Current carry flag |
| in_flag_req | input | 1 | Operation wants flags updated |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Shifted or expanded word |
| out_carry | output | 1 | Carry-out |
| out_carry_upd | output | 1 | Carry flag should be written |

## Verification
Every result is due exactly one clock after the edge that accepts its operation. It then stays on the output for as many extra cycles as `out_ready` is held low. With back-pressure off, the bench confirms that `out_valid` rises at the first falling edge after acceptance. For the rest, a scoreboard queues each expected result when its operation is accepted. That result is compared only at a falling edge where both `out_valid` and `out_ready` are high, which is the cycle in which the output really transfers. A separate stall check confirms that a held result does not change between falling edges.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  localparam int unsigned KIND_W = 3;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bsx_shift_core.sv
module bsx_shift_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [bsx_pkg::KIND_W-1:0] kind,
  input  logic [AMT_W-1:0]           amount,
  input  logic [DATA_W-1:0]          operand,
  input  logic                       carry_in,
  output logic [DATA_W-1:0]          result,
  output logic                       carry_out,
  output logic                       carry_live
);
  import bsx_pkg::*;

  localparam int unsigned ROT_W = $clog2(DATA_W);

  logic              zero_amt;
  logic [DATA_W:0]   lsl_w;
  logic [DATA_W:0]   lsr_w;
  logic [DATA_W:0]   asr_w;
  logic [ROT_W-1:0]  ror_amt;
  logic [DATA_W-1:0] ror_res;

  assign zero_amt = (amount == '0);
  assign ror_amt  = amount[ROT_W-1:0];

  // One extra bit on the far side of each shift catches the last bit out.
  assign lsl_w   = {1'b0, operand} << amount;
  assign lsr_w   = {operand, 1'b0} >> amount;
  assign asr_w   = $signed({operand, 1'b0}) >>> amount;
  assign ror_res = (operand >> ror_amt)
                 | (operand << ((ROT_W+1)'(DATA_W) - {1'b0, ror_amt}));

  always_comb begin
    result     = operand;
    carry_out  = carry_in;
    carry_live = 1'b0;
    unique case (kind)
      SK_LSL: if (!zero_amt) begin
        result     = lsl_w[DATA_W-1:0];
        carry_out  = lsl_w[DATA_W];
        carry_live = 1'b1;
      end
      SK_LSR: if (!zero_amt) begin
        result     = lsr_w[DATA_W:1];
        carry_out  = lsr_w[0];
        carry_live = 1'b1;
      end
      SK_ASR: if (!zero_amt) begin
        result     = asr_w[DATA_W:1];
        carry_out  = asr_w[0];
        carry_live = 1'b1;
      end
      SK_ROR: if (!zero_amt) begin
        result     = ror_res;
        carry_out  = ror_res[DATA_W-1];
        carry_live = 1'b1;
      end
      SK_RRX: begin
        result     = {carry_in, operand[DATA_W-1:1]};
        carry_out  = operand[0];
        carry_live = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsx_imm_expand.sv
module bsx_imm_expand #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 12
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              carry_in,
  output logic [DATA_W-1:0] value,
  output logic              carry_out,
  output logic              carry_live
);
  import bsx_pkg::*;

  localparam int unsigned LANES   = DATA_W / BYTE_W;
  localparam int unsigned ROT_W   = $clog2(DATA_W);
  localparam int unsigned SEL_LO  = BYTE_W;
  localparam int unsigned FORM_LO = BYTE_W + 2;
  localparam int unsigned ROT_LO  = IMM_W - ROT_W;

  logic [BYTE_W-1:0] byte_v;
  logic [1:0]        pat_sel;
  logic              rotated;
  logic [ROT_W-1:0]  rot_amt;
  logic [DATA_W-1:0] rot_base;
  logic [DATA_W-1:0] rot_val;
  logic [DATA_W-1:0] pat_val;

  assign byte_v  = imm[BYTE_W-1:0];
  assign pat_sel = imm[SEL_LO+1:SEL_LO];
  assign rotated = (imm[FORM_LO+1:FORM_LO] != 2'b00);
  assign rot_amt = imm[IMM_W-1:ROT_LO];

  assign rot_base = {{(DATA_W-BYTE_W){1'b0}}, 1'b1, imm[BYTE_W-2:0]};
  assign rot_val  = (rot_base >> rot_amt)
                  | (rot_base << ((ROT_W+1)'(DATA_W) - {1'b0, rot_amt}));

  // Each byte lane takes the byte or zero, depending on the pattern selector.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    always_comb begin
      unique case (pat_sel)
        2'b00:   lane_on = (g == 0);
        2'b01:   lane_on = (g % 2 == 0);
        2'b10:   lane_on = (g % 2 == 1);
        default: lane_on = 1'b1;
      endcase
    end
    assign pat_val[g*BYTE_W +: BYTE_W] = lane_on ? byte_v : '0;
  end

  assign value      = rotated ? rot_val : pat_val;
  assign carry_out  = rotated ? rot_val[DATA_W-1] : carry_in;
  assign carry_live = rotated;
endmodule

// File: rtl/bsx_out_stage.sv
module bsx_out_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_carry,
  input  logic              d_upd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] q_result,
  output logic              q_carry,
  output logic              q_upd
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (in_ready)  out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      q_result <= d_result;
      q_carry  <= d_carry;
      q_upd    <= d_upd;
    end
  end
endmodule

// File: rtl/bsx_operand_unit.sv
module bsx_operand_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8,
  parameter int unsigned IMM_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_imm_mode,
  input  logic [bsx_pkg::KIND_W-1:0] in_kind,
  input  logic [AMT_W-1:0]           in_amount,
  input  logic [DATA_W-1:0]          in_operand,
  input  logic [IMM_W-1:0]           in_imm12,
  input  logic                       in_carry,
  input  logic                       in_flag_req,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DATA_W-1:0]          out_result,
  output logic                       out_carry,
  output logic                       out_carry_upd
);
  logic [DATA_W-1:0] sh_res, im_res, sel_res;
  logic              sh_c, im_c, sel_c;
  logic              sh_live, im_live, sel_upd;

  bsx_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_shift (
    .kind       (in_kind),
    .amount     (in_amount),
    .operand    (in_operand),
    .carry_in   (in_carry),
    .result     (sh_res),
    .carry_out  (sh_c),
    .carry_live (sh_live)
  );

  bsx_imm_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_imm (
    .imm        (in_imm12),
    .carry_in   (in_carry),
    .value      (im_res),
    .carry_out  (im_c),
    .carry_live (im_live)
  );

  assign sel_res = in_imm_mode ? im_res  : sh_res;
  assign sel_c   = in_imm_mode ? im_c    : sh_c;
  assign sel_upd = in_flag_req && (in_imm_mode ? im_live : sh_live);

  bsx_out_stage #(.DATA_W(DATA_W)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_result  (sel_res),
    .d_carry   (sel_c),
    .d_upd     (sel_upd),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_result  (out_result),
    .q_carry   (out_carry),
    .q_upd     (out_carry_upd)
  );
endmodule

// File: rtl/bsx_operand_sva.sv
module bsx_operand_sva #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       in_imm_mode,
  input logic [bsx_pkg::KIND_W-1:0] in_kind,
  input logic [AMT_W-1:0]           in_amount,
  input logic [DATA_W-1:0]          in_operand,
  input logic                       in_carry,
  input logic                       in_flag_req,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DATA_W-1:0]          out_result,
  input logic                       out_carry,
  input logic                       out_carry_upd
);
  import bsx_pkg::*;

  logic fire;
  assign fire = in_valid && in_ready;

  assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_carry) && $stable(out_carry_upd)));

  assert_no_req_no_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_flag_req) |=> !out_carry_upd);

  assert_carry_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_imm_mode && in_kind == SK_RRX)
      |=> (out_result == {$past(in_carry), $past(in_operand[DATA_W-1:1])}
           && out_carry == $past(in_operand[0])));

  assert_zero_amount_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_imm_mode && in_kind < SK_RRX && in_amount == '0)
      |=> (out_result == $past(in_operand) && out_carry == $past(in_carry)
           && !out_carry_upd));
endmodule

bind bsx_operand_unit bsx_operand_sva #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_sva (.*);

// File: tb/test_bsx_operand_unit.sv
module test_bsx_operand_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_imm_mode = 1'b0;
  logic [2:0]  in_kind = '0;
  logic [7:0]  in_amount = '0;
  logic [31:0] in_operand = '0;
  logic [11:0] in_imm12 = '0;
  logic        in_carry = 1'b0;
  logic        in_flag_req = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_carry;
  logic        out_carry_upd;

  always #4 clk = ~clk;

  bsx_operand_unit i_bsx_operand_unit (.*);

  typedef struct {
    logic [31:0] r;
    logic        c;
    logic        u;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   bp       = 1'b0;
  bit   chk_lat  = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_model(
    input logic imm, input logic [2:0] k, input logic [7:0] a, input logic [31:0] x,
    input logic [11:0] im, input logic cin, input logic fr,
    output logic [31:0] r, output logic c, output logic u);
    logic [7:0] b;
    r = x; c = cin; u = 1'b0;
    if (imm) begin
      b = im[7:0];
      if (im[11:10] == 2'b00) begin
        case (im[9:8])
          2'b00: r = {24'h0, b};
          2'b01: r = {8'h0, b, 8'h0, b};
          2'b10: r = {b, 8'h0, b, 8'h0};
          default: r = {b, b, b, b};
        endcase
      end else begin
        r = {24'h0, 1'b1, im[6:0]};
        for (int i = 0; i < int'(im[11:7]); i++) r = {r[0], r[31:1]};
        c = r[31];
        u = fr;
      end
    end else begin
      case (k)
        3'd0: for (int i = 0; i < int'(a); i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
        3'd1: for (int i = 0; i < int'(a); i++) begin c = r[0]; r = {1'b0, r[31:1]}; end
        3'd2: for (int i = 0; i < int'(a); i++) begin c = r[0]; r = {r[31], r[31:1]}; end
        3'd3: begin
          for (int i = 0; i < int'(a); i++) r = {r[0], r[31:1]};
          if (a != 0) c = r[31];
        end
        3'd4: begin c = x[0]; r = {cin, x[31:1]}; end
        default: ;
      endcase
      u = fr && ((k <= 3'd3 && a != 0) || k == 3'd4);
    end
  endfunction

  function automatic string tag_of(input logic imm, input logic [2:0] k, input logic [7:0] a, input logic [11:0] im);
    if (imm) return (im[11:10] == 2'b00) ? "R8" : "R7";
    if (k > 3'd4) return "R13";
    if (k != 3'd4 && a == 0) return "R6";
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Driver: called at a falling edge, returns at a falling edge.
  task automatic send(input logic imm, input logic [2:0] k, input logic [7:0] a,
                      input logic [31:0] x, input logic [11:0] im, input logic cin, input logic fr);
    exp_t e;
    ref_model(imm, k, a, x, im, cin, fr, e.r, e.c, e.u);
    e.tag = tag_of(imm, k, a, im);
    in_imm_mode = imm; in_kind = k; in_amount = a; in_operand = x;
    in_imm12 = im; in_carry = cin; in_flag_req = fr; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q.push_back(e);
    @(negedge clk);
    if (chk_lat) check(out_valid === 1'b1, "R10 latency", {31'h0, out_valid}, 32'h1);
  endtask

  // Back-pressure pattern changes just after each rising edge.
  always @(posedge clk) begin
    #1;
    out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
  end

  // Monitor and scoreboard.
  logic        held_v = 1'b0;
  logic [31:0] held_r;
  logic        held_c, held_u;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v) begin
        check(out_valid === 1'b1 && out_result === held_r && out_carry === held_c
              && out_carry_upd === held_u, "R11 stall hold", out_result, held_r);
      end
      held_v = out_valid && !out_ready;
      held_r = out_result; held_c = out_carry; held_u = out_carry_upd;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected output", out_result, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_result === e.r && out_carry === e.c, e.tag, {out_carry, out_result[30:0]}, {e.c, e.r[30:0]});
          if (out_result !== e.r) $display("  (%s full result actual=%h expected=%h)", e.tag, out_result, e.r);
          check(out_carry_upd === e.u, "R9 carry update", {31'h0, out_carry_upd}, {31'h0, e.u});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R10 watchdog expired", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] edges [6];
    edges = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R12 reset state", {30'h0, out_valid, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R12 after reset", {30'h0, out_valid, in_ready}, 32'h1);

    // Edge amounts for each shift code, no back-pressure, latency checked.
    chk_lat = 1'b1;
    for (int k = 0; k < 5; k++)
      for (int j = 0; j < 6; j++)
        for (int t = 0; t < 2; t++)
          send(1'b0, 3'(k), edges[j], (t == 0) ? 32'h8000_0001 : $urandom, 12'h0, 1'($urandom), 1'b1);
    // Reserved codes R13.
    for (int k = 5; k < 8; k++) send(1'b0, 3'(k), 8'd7, $urandom, 12'h0, 1'b1, 1'b1);
    // Replicated byte patterns R8.
    for (int s = 0; s < 4; s++) begin
      send(1'b1, 3'd0, 8'd0, 32'h0, {2'b00, 2'(s), 8'hA5}, 1'b1, 1'b1);
      send(1'b1, 3'd0, 8'd0, 32'h0, {2'b00, 2'(s), 8'h3C}, 1'b0, 1'b1);
    end
    // Rotated immediates R7, including smallest and largest rotations.
    send(1'b1, 3'd0, 8'd0, 32'h0, 12'h400, 1'b0, 1'b1);
    send(1'b1, 3'd0, 8'd0, 32'h0, 12'hFFF, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      logic [11:0] im;
      im = 12'($urandom);
      if (im[11:10] == 2'b00) im[11] = 1'b1;
      send(1'b1, 3'd0, 8'd0, 32'h0, im, 1'($urandom), 1'b1);
    end
    // No flag request: R9 must keep the update low.
    for (int i = 0; i < 10; i++)
      send(1'($urandom), 3'($urandom % 5), 8'($urandom), $urandom, 12'hC81, 1'($urandom), 1'b0);

    // Random mix under back-pressure.
    chk_lat = 1'b0;
    bp = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      a = (i % 2 == 0) ? edges[$urandom % 6] : 8'($urandom);
      send(1'($urandom % 4 == 0), 3'($urandom), a, $urandom, 12'($urandom), 1'($urandom), 1'($urandom));
    end
    in_valid = 1'b0;
    bp = 1'b0;
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R10 drained", q.size(), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule